// File: doc/BRIEF.md
# Coherence State Controller for Snooped Cache Lines

This block holds the four-state coherence record (modified, exclusive, shared, invalid) for a small set of cache lines belonging to one processor, each line standing for a 32-byte block. It reacts to two request streams: local requests from the processor side (read miss, write hit, write miss) and transactions snooped from the system bus (plain read, and read with intent to modify). Data storage, tag matching and bus arbitration sit outside; the block is given a line index with each request.

Snooped reads that find a clean copy answer with a shared response and demote the local copy to shared, so both processors keep a readable copy. A snooped hit on modified data answers with retry and a write-back request, so the block reaches memory before the requester gets it. Local fills sample the other caches' shared response to choose between exclusive and shared. Local writes to a shared or absent line raise an ownership request on the bus; writes to exclusive lines are silent.

The local request port is valid/ready: a snoop in the same cycle takes precedence and drops ready, and the requester must hold its request until ready is seen high. Snoops are never stalled.

Top module: `mesi_line_ctl`

## Requirements
- R1: After reset every line reads invalid and all response outputs are low; state encoding on qry_state is invalid=0, shared=1, exclusive=2, modified=3.
- R2: An accepted local read miss (lreq_op=0) installs the line exclusive when fill_shared is low and shared when fill_shared is high, with no ownership request.
- R3: An accepted local write hit (lreq_op=1) to an exclusive or modified line leaves it modified and raises no bus_own.
- R4: An accepted local write hit to a shared or invalid line, or any accepted write miss (lreq_op=2), leaves the line modified and pulses bus_own.
- R5: A snooped read (snp_op=0) hitting an exclusive or shared line pulses snp_shared and leaves the line shared.
- R6: A snooped read hitting a modified line pulses snp_retry and wb_req with wb_idx equal to the snooped index, and leaves the line shared.
- R7: A snooped read-with-intent-to-modify (snp_op=1) invalidates any valid line; if the line was modified, snp_retry and wb_req pulse with wb_idx set to that index.
- R8: A snoop to an invalid line produces no response and changes no state.
- R9: While snp_valid is high lreq_ready is low and the local request has no effect on state or bus_own.
- R10: lreq_op=3 is ignored: no state change and no bus_own.
- R11: Response outputs are registered: they appear in the cycle after the accepting clock edge and last one cycle; qry_state shows the updated state right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq_valid | input | 1 | Local request present |
| lreq_ready | output | 1 | Local request accepted this cycle |
| lreq_op | input | 2 | 0 read miss, 1 write hit, 2 write miss, 3 ignored |
| lreq_idx | input | IW | Line index of local request |
| fill_shared | input | 1 | Shared response sampled from other caches during a fill |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 1 | 0 read, 1 read with intent to modify |
| snp_idx | input | IW | Line index hit by the snoop |
| qry_idx | input | IW | Line to report on qry_state |
| qry_state | output | 2 | Coherence state of line qry_idx |
| snp_shared | output | 1 | Shared response to a snoop |
| snp_retry | output | 1 | Retry / intervention: modified data held |
| wb_req | output | 1 | Write-back of a modified line requested |
| wb_idx | output | IW | Line to write back |
| bus_own | output | 1 | Ownership (invalidate) request on the bus |

## Verification
The awkward case is a snoop landing on a line in the very cycle the processor tries to change it, since the snoop must win and the local request must leave no trace. The random stimulus draws line indices from a set of only four, so local and snooped requests collide on the same line often, and directed steps force a write to a shared line to coincide with a snoop to it, then show the request completing once ready returns.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    LOP_RDMISS = 2'd0,
    LOP_WRHIT  = 2'd1,
    LOP_WRMISS = 2'd2,
    LOP_NONE   = 2'd3
  } lop_t;

  localparam logic SOP_READ  = 1'b0;
  localparam logic SOP_RWITM = 1'b1;
endpackage

// File: rtl/mesi_local_next.sv
`timescale 1ns/1ps
module mesi_local_next
  import mesi_pkg::*;
(
  input  mesi_t     cur,
  input  logic [1:0] op,
  input  logic      fill_shared,
  output mesi_t     nxt,
  output logic      upd,
  output logic      own
);
  always_comb begin
    nxt = cur;
    upd = 1'b0;
    own = 1'b0;
    unique case (op)
      LOP_RDMISS: begin
        nxt = fill_shared ? ST_S : ST_E;
        upd = 1'b1;
      end
      LOP_WRHIT: begin
        nxt = ST_M;
        upd = 1'b1;
        own = (cur == ST_S) || (cur == ST_I);
      end
      LOP_WRMISS: begin
        nxt = ST_M;
        upd = 1'b1;
        own = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mesi_snoop_next.sv
`timescale 1ns/1ps
module mesi_snoop_next
  import mesi_pkg::*;
(
  input  mesi_t cur,
  input  logic  op,
  output mesi_t nxt,
  output logic  shared,
  output logic  retry
);
  always_comb begin
    retry  = (cur == ST_M);
    shared = (op == SOP_READ) && ((cur == ST_E) || (cur == ST_S));
    if (cur == ST_I)         nxt = ST_I;
    else if (op == SOP_RWITM) nxt = ST_I;
    else                     nxt = ST_S;
  end
endmodule

// File: rtl/mesi_line_cell.sv
`timescale 1ns/1ps
module mesi_line_cell
  import mesi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  mesi_t d,
  output mesi_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= ST_I;
    else if (we) q <= d;
  end
endmodule

// File: rtl/mesi_line_ctl.sv
`timescale 1ns/1ps
module mesi_line_ctl
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lreq_valid,
  output logic          lreq_ready,
  input  logic [1:0]    lreq_op,
  input  logic [IW-1:0] lreq_idx,
  input  logic          fill_shared,
  input  logic          snp_valid,
  input  logic          snp_op,
  input  logic [IW-1:0] snp_idx,
  input  logic [IW-1:0] qry_idx,
  output logic [1:0]    qry_state,
  output logic          snp_shared,
  output logic          snp_retry,
  output logic          wb_req,
  output logic [IW-1:0] wb_idx,
  output logic          bus_own
);
  mesi_t lines [LINES];
  logic [2*LINES-1:0] lines_flat;

  mesi_t loc_cur, loc_nxt, snp_cur, snp_nxt;
  logic  loc_upd, loc_own, snp_sh, snp_rt;
  logic  loc_take;

  assign lreq_ready = !snp_valid;
  assign loc_take   = lreq_valid && lreq_ready;
  assign loc_cur    = lines[lreq_idx];
  assign snp_cur    = lines[snp_idx];

  mesi_local_next u_loc (
    .cur(loc_cur), .op(lreq_op), .fill_shared(fill_shared),
    .nxt(loc_nxt), .upd(loc_upd), .own(loc_own)
  );

  mesi_snoop_next u_snp (
    .cur(snp_cur), .op(snp_op),
    .nxt(snp_nxt), .shared(snp_sh), .retry(snp_rt)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic  we;
    mesi_t d;
    always_comb begin
      if (snp_valid && (snp_idx == IW'(g))) begin
        we = 1'b1;
        d  = snp_nxt;
      end else begin
        we = loc_take && loc_upd && (lreq_idx == IW'(g));
        d  = loc_nxt;
      end
    end
    mesi_line_cell u_cell (.clk(clk), .rst_n(rst_n), .we(we), .d(d), .q(lines[g]));
    assign lines_flat[2*g +: 2] = lines[g];
  end

  assign qry_state = lines[qry_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_shared <= 1'b0;
      snp_retry  <= 1'b0;
      wb_req     <= 1'b0;
      wb_idx     <= '0;
      bus_own    <= 1'b0;
    end else begin
      snp_shared <= snp_valid && snp_sh;
      snp_retry  <= snp_valid && snp_rt;
      wb_req     <= snp_valid && snp_rt;
      if (snp_valid && snp_rt) wb_idx <= snp_idx;
      bus_own    <= loc_take && loc_own;
    end
  end
endmodule

// File: rtl/mesi_line_ctl_chk.sv
`timescale 1ns/1ps
module mesi_line_ctl_chk #(
  parameter int LINES = 4,
  parameter int IW = 2
)(
  input logic               clk,
  input logic               rst_n,
  input logic               lreq_valid,
  input logic [1:0]         lreq_op,
  input logic [IW-1:0]      lreq_idx,
  input logic               snp_valid,
  input logic               snp_op,
  input logic [IW-1:0]      snp_idx,
  input logic               snp_shared,
  input logic               snp_retry,
  input logic               wb_req,
  input logic               bus_own,
  input logic [2*LINES-1:0] lines_flat
);
  function automatic logic [1:0] st_of(input logic [2*LINES-1:0] v, input logic [IW-1:0] i);
    return v[2*i +: 2];
  endfunction

  a_r6_retry_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> wb_req);

  a_r5_clean_read_shares: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_op && (st_of(lines_flat, snp_idx) == 2'd2 || st_of(lines_flat, snp_idx) == 2'd1))
    |=> (snp_shared && st_of(lines_flat, $past(snp_idx)) == 2'd1));

  a_r7_rwitm_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op) |=> (st_of(lines_flat, $past(snp_idx)) == 2'd0));

  a_r3_exclusive_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_valid && !snp_valid && lreq_op == 2'd1 && st_of(lines_flat, lreq_idx) == 2'd2)
    |=> !bus_own);

  a_r8_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!snp_valid && !lreq_valid) |=> $stable(lines_flat));

  a_r9_no_own_during_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !bus_own);

  a_r5_no_dual_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_shared && snp_retry));
endmodule

bind mesi_line_ctl mesi_line_ctl_chk #(.LINES(LINES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lreq_valid(lreq_valid), .lreq_op(lreq_op),
  .lreq_idx(lreq_idx), .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
  .snp_shared(snp_shared), .snp_retry(snp_retry), .wb_req(wb_req),
  .bus_own(bus_own), .lines_flat(lines_flat)
);

// File: tb/mesi_line_ctl_test.sv
`timescale 1ns/1ps
module mesi_line_ctl_test;
  localparam int LINES = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lreq_valid = 1'b0, fill_shared = 1'b0, snp_valid = 1'b0, snp_op = 1'b0;
  logic [1:0] lreq_op = 2'd3;
  logic [IW-1:0] lreq_idx = '0, snp_idx = '0, qry_idx = '0;
  logic lreq_ready, snp_shared, snp_retry, wb_req, bus_own;
  logic [1:0] qry_state;
  logic [IW-1:0] wb_idx;

  int vectors = 0;
  int fails = 0;
  logic [1:0] m [LINES];

  always #2.5 clk = ~clk;

  mesi_line_ctl #(.LINES(LINES)) uut (
    .clk(clk), .rst_n(rst_n), .lreq_valid(lreq_valid), .lreq_ready(lreq_ready),
    .lreq_op(lreq_op), .lreq_idx(lreq_idx), .fill_shared(fill_shared),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
    .qry_idx(qry_idx), .qry_state(qry_state), .snp_shared(snp_shared),
    .snp_retry(snp_retry), .wb_req(wb_req), .wb_idx(wb_idx), .bus_own(bus_own)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] loc_next(input logic [1:0] c, input logic [1:0] op, input logic fs);
    case (op)
      2'd0: return fs ? 2'd1 : 2'd2;
      2'd1, 2'd2: return 2'd3;
      default: return c;
    endcase
  endfunction

  function automatic logic [1:0] snp_next(input logic [1:0] c, input logic op);
    if (c == 2'd0) return 2'd0;
    return op ? 2'd0 : 2'd1;
  endfunction

  // one cycle of stimulus; expected values from the model
  task automatic step(input logic lv, input logic [1:0] lop, input logic [IW-1:0] li,
                      input logic fs, input logic sv, input logic sop,
                      input logic [IW-1:0] si, input logic [IW-1:0] qi);
    logic e_sh, e_rt, e_own, e_rdy;
    logic [1:0] lc, sc;
    @(negedge clk);
    lreq_valid = lv; lreq_op = lop; lreq_idx = li; fill_shared = fs;
    snp_valid = sv; snp_op = sop; snp_idx = si; qry_idx = qi;
    #0.5;
    e_rdy = !sv;
    chk(lreq_ready == e_rdy, "R9 ready", lreq_ready, e_rdy);
    sc = m[si]; lc = m[li];
    e_sh = sv && !sop && (sc == 2'd1 || sc == 2'd2);
    e_rt = sv && (sc == 2'd3);
    e_own = !sv && lv && (lop == 2'd2 || (lop == 2'd1 && (lc == 2'd0 || lc == 2'd1)));
    if (sv) m[si] = snp_next(sc, sop);
    else if (lv) m[li] = loc_next(lc, lop, fs);
    @(posedge clk);
    #1;
    chk(snp_shared == e_sh, "R5 snp_shared", snp_shared, e_sh);
    chk(snp_retry == e_rt, "R6/R7 snp_retry", snp_retry, e_rt);
    chk(wb_req == e_rt, "R6/R7 wb_req", wb_req, e_rt);
    if (e_rt) chk(wb_idx == si, "R6/R7 wb_idx", wb_idx, si);
    chk(bus_own == e_own, "R4 bus_own", bus_own, e_own);
    chk(qry_state == m[qi], "R11 qry_state", qry_state, m[qi]);
  endtask

  task automatic idle_scan();
    for (int i = 0; i < LINES; i++) begin
      @(negedge clk);
      lreq_valid = 0; snp_valid = 0; qry_idx = IW'(i);
      #0.5;
      chk(qry_state == m[i], "R8 state scan", qry_state, m[i]);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) m[i] = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    #0.5;
    chk(!snp_shared && !snp_retry && !wb_req && !bus_own, "R1 outputs", 1, 0);
    idle_scan();
    // R2 fills
    step(1, 2'd0, 0, 0, 0, 0, 0, 0);   // line0 E
    chk(qry_state == 2'd2, "R2 fill exclusive", qry_state, 2);
    step(1, 2'd0, 1, 1, 0, 0, 0, 1);   // line1 S
    chk(qry_state == 2'd1, "R2 fill shared", qry_state, 1);
    // R5 snoop read on E
    step(0, 2'd3, 0, 0, 1, 0, 0, 0);
    // R4 write to S -> M, own
    step(1, 2'd1, 0, 0, 0, 0, 0, 0);
    chk(bus_own, "R4 write shared", bus_own, 1);
    // R6 snoop read on M
    step(0, 2'd3, 0, 0, 1, 0, 0, 0);
    chk(snp_retry && qry_state == 2'd1, "R6 modified read", qry_state, 1);
    // R3 silent write on E
    step(1, 2'd0, 2, 0, 0, 0, 0, 2);
    step(1, 2'd1, 2, 0, 0, 0, 0, 2);
    chk(!bus_own && qry_state == 2'd3, "R3 exclusive write", bus_own, 0);
    // R7 rwitm on M and on S
    step(0, 2'd3, 0, 0, 1, 1, 2, 2);
    chk(wb_req && qry_state == 2'd0, "R7 rwitm modified", qry_state, 0);
    step(0, 2'd3, 0, 0, 1, 1, 1, 1);
    chk(!wb_req && qry_state == 2'd0, "R7 rwitm shared", qry_state, 0);
    // R8 snoop on invalid
    step(0, 2'd3, 0, 0, 1, 0, 3, 3);
    // R9 collision: write to shared line while snooped
    step(1, 2'd0, 3, 1, 0, 0, 0, 3);   // line3 S
    step(1, 2'd1, 3, 0, 1, 0, 3, 3);
    chk(!bus_own && qry_state == 2'd1, "R9 collision blocked", qry_state, 1);
    step(1, 2'd1, 3, 0, 0, 0, 0, 3);
    chk(bus_own && qry_state == 2'd3, "R9 retried write", qry_state, 3);
    // R10 op 3 ignored
    step(1, 2'd3, 3, 0, 0, 0, 0, 3);
    chk(!bus_own && qry_state == 2'd3, "R10 op3 ignored", qry_state, 3);
    // write miss
    step(1, 2'd2, 1, 0, 0, 0, 0, 1);
    chk(bus_own, "R4 write miss", bus_own, 1);
    idle_scan();
    // random
    for (int n = 0; n < 3000; n++) begin
      step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), IW'($urandom_range(0, LINES-1)),
           1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0),
           1'($urandom_range(0, 1)), IW'($urandom_range(0, LINES-1)),
           IW'($urandom_range(0, LINES-1)));
      if (n % 500 == 0) idle_scan();
    end
    idle_scan();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule